// File: doc/BRIEF.md
# Parallel-Load Shift Register with J-K Entry Stage

This block is a small rising-edge shift register, four stages wide by default. Each clock edge does one of two things, chosen by an active-low load-select input. With load-select low, every stage captures its own parallel data input. With load-select high, the contents move one place from stage 0 toward the last stage, and stage 0 takes a new value from a pair of serial control inputs.

The serial pair is a J input and an active-low K input. Together they let stage 0 be set, cleared, toggled or held while the shift goes on. If both serial pins are tied together, the pair acts as a plain D-type serial input.

An active-low master reset clears every stage at once, without waiting for a clock edge, and it overrides all other inputs. The outputs are the stage values and a separate pin that always shows the inverse of the last stage.

Top module: `jk_shift_reg`

## Requirements
- R1: While `rst_n` is low, `q` is all zeros at once, without a clock edge, and `q_last_n` is 1.
- R2: At a rising edge with `load_n` = 0, `q` takes the value of `par_d` (bit i into stage i), whatever `ser_j` and `ser_kb` are.
- R3: At a rising edge with `load_n` = 1, `q[i]` takes the old `q[i-1]` for every i from 1 to WIDTH-1.
- R4: During a shift, `ser_j` = 1 with `ser_kb` = 1 makes `q[0]` become 1.
- R5: During a shift, `ser_j` = 0 with `ser_kb` = 0 makes `q[0]` become 0.
- R6: During a shift, `ser_j` = 1 with `ser_kb` = 0 makes `q[0]` become the inverse of its old value.
- R7: During a shift, `ser_j` = 0 with `ser_kb` = 1 leaves `q[0]` at its old value.
- R8: `q_last_n` is always the inverse of `q[WIDTH-1]`.
- R9: When `ser_j` and `ser_kb` carry the same value, a shift puts that value into `q[0]`.
- R10: After `rst_n` goes high, the first rising edge does a normal load or shift, based on the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register changes on its rising edge |
| rst_n | input | 1 | Asynchronous master reset, active low |
| load_n | input | 1 | 0 = parallel load, 1 = shift toward the last stage |
| ser_j | input | 1 | J serial control for stage 0 |
| ser_kb | input | 1 | Active-low K serial control for stage 0 |
| par_d | input | WIDTH | Parallel data; bit i goes to stage i |
| q | output | WIDTH | Stage values |
| q_last_n | output | 1 | Inverse of the last stage |

## Verification
The hardest case to reach is a reset pulse that arrives part-way through a clock period, in the middle of a run of loads and shifts, and is then released before the next edge. This case covers two requirements at once: the outputs must clear at once without a clock edge (R1), and the first edge after release must behave normally (R10). The bench places the reset edges away from clock edges at random points in a random sequence and samples `q` before any clock edge occurs. The toggle and hold codes only show their effect when stage 0 already holds a known non-reset value. For that reason the stimulus mixes loads of random patterns with long runs of shifts.

// File: rtl/shreg_jk_pkg.sv
// Package: shared definitions for the J-K entry shift register.
// Assumes: nothing beyond IEEE 1800-2017.
package shreg_jk_pkg;
    // Serial control code formed as {j, kb}
    typedef enum logic [1:0] {
        JK_CLEAR  = 2'b00,
        JK_HOLD   = 2'b01,
        JK_TOGGLE = 2'b10,
        JK_SET    = 2'b11
    } jk_code_t;
endpackage

// File: rtl/jk_first_stage.sv
// Module: jk_first_stage
// Works out the next value of stage 0 for a shift from the J / active-low K
// pair and the current stage 0 value. Purely combinational.
// Assumes: the caller selects this result only on shift cycles.
module jk_first_stage
    import shreg_jk_pkg::*;
(
    input  logic cur_q0,
    input  logic ser_j,
    input  logic ser_kb,
    output logic next_q0
);
    jk_code_t code;

    // Decode the serial pair into set, clear, toggle or hold
    always_comb begin
        code = jk_code_t'({ser_j, ser_kb});
        unique case (code)
            JK_SET:    next_q0 = 1'b1;
            JK_CLEAR:  next_q0 = 1'b0;
            JK_TOGGLE: next_q0 = ~cur_q0;
            JK_HOLD:   next_q0 = cur_q0;
            default:   next_q0 = cur_q0;
        endcase
    end
endmodule

// File: rtl/shift_stage_bank.sv
// Module: shift_stage_bank
// Holds the WIDTH stage flops. Each stage picks its parallel input on a load
// or its lower neighbour on a shift; stage 0 takes head_next on a shift.
// Assumes: rst_n is an asynchronous active-low clear (the block needs an
// overriding clear, so this bank does not follow the synchronous default).
module shift_stage_bank #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             head_next,
    input  logic [WIDTH-1:0] par_d,
    output logic [WIDTH-1:0] stages
);
    logic [WIDTH-1:0] nxt;

    // Stage 0 source: parallel bit or the J-K decode
    assign nxt[0] = load_n ? head_next : par_d[0];

    // Upper stages: parallel bit or the stage below
    generate
        for (genvar i = 1; i < WIDTH; i++) begin : g_stage
            assign nxt[i] = load_n ? stages[i-1] : par_d[i];
        end
    endgenerate

    // Stage flops with asynchronous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stages <= '0;
        else        stages <= nxt;
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk) !rst_n |-> stages == '0);
    // R2
    par_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> stages == $past(par_d));
    // R3
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> stages[WIDTH-1:1] == $past(stages[WIDTH-2:0]));
endmodule

// File: rtl/jk_shift_reg.sv
// Module: jk_shift_reg (top)
// Shift register, loaded in parallel, with a J-K controlled entry stage and an
// inverted last-stage output.
// Assumes: WIDTH >= 2; rst_n is asynchronous and overrides all other inputs.
module jk_shift_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             ser_j,
    input  logic             ser_kb,
    input  logic [WIDTH-1:0] par_d,
    output logic [WIDTH-1:0] q,
    output logic             q_last_n
);
    localparam int LAST = WIDTH - 1;

    logic head_next;

    jk_first_stage u_head (
        .cur_q0 (q[0]),
        .ser_j  (ser_j),
        .ser_kb (ser_kb),
        .next_q0(head_next)
    );

    shift_stage_bank #(.WIDTH(WIDTH)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n   (load_n),
        .head_next(head_next),
        .par_d    (par_d),
        .stages   (q)
    );

    // Inverted view of the last stage
    assign q_last_n = ~q[LAST];

    // R4
    head_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && ser_j && ser_kb) |=> q[0]);
    // R5
    head_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !ser_j && !ser_kb) |=> !q[0]);
    // R6
    head_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && ser_j && !ser_kb) |=> q[0] != $past(q[0]));
    // R7
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !ser_j && ser_kb) |=> $stable(q[0]));
    // R8
    last_inv_chk: assert property (@(posedge clk) q_last_n != q[LAST]);
endmodule

// File: tb/jk_shift_reg_bench.sv
`timescale 1ns/1ps
module jk_shift_reg_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_n = 1'b1;
    logic         ser_j = 1'b0;
    logic         ser_kb = 1'b0;
    logic [W-1:0] par_d = '0;
    logic [W-1:0] q;
    logic         q_last_n;

    int vectors = 0;
    int misses = 0;
    logic [W-1:0] model = '0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    jk_shift_reg #(.WIDTH(W)) u_jk_shift_reg (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .ser_j(ser_j),
        .ser_kb(ser_kb), .par_d(par_d), .q(q), .q_last_n(q_last_n)
    );

    // Reference next state, from the requirements
    function automatic logic [W-1:0] ref_next(logic [W-1:0] cur, logic ld_n,
                                              logic j, logic kb, logic [W-1:0] d);
        logic h;
        if (!ld_n) return d;
        case ({j, kb})
            2'b11: h = 1'b1;
            2'b00: h = 1'b0;
            2'b10: h = ~cur[0];
            default: h = cur[0];
        endcase
        return {cur[W-2:0], h};
    endfunction

    function automatic string tag_of(logic ld_n, logic j, logic kb);
        if (!ld_n) return "R2";
        case ({j, kb})
            2'b11: return "R3/R4/R9";
            2'b00: return "R3/R5/R9";
            2'b10: return "R3/R6";
            default: return "R3/R7";
        endcase
    endfunction

    task automatic check(string tag);
        vectors++;
        if (q !== model || q_last_n !== ~model[W-1]) begin
            misses++;
            $display("FAIL %s (R8 inv): q=%b q_last_n=%b expected q=%b q_last_n=%b",
                     tag, q, q_last_n, model, ~model[W-1]);
        end
    endtask

    // One clock: drive at falling edge, update model at rising edge, sample 1 ns later
    task automatic step(logic ld_n, logic j, logic kb, logic [W-1:0] d, string extra);
        @(negedge clk);
        load_n = ld_n; ser_j = j; ser_kb = kb; par_d = d;
        @(posedge clk);
        model = ref_next(model, ld_n, j, kb, d);
        #1;
        check({tag_of(ld_n, j, kb), extra});
    endtask

    // Reset pulse that starts and ends between clock edges
    task automatic mid_reset(int hold_cycles);
        @(negedge clk);
        #0.7;
        rst_n = 1'b0;
        #0.3;
        model = '0;
        check("R1 async clear");
        for (int c = 0; c < hold_cycles; c++) @(posedge clk);
        #1.2;
        rst_n = 1'b1;
        #0.2;
        check("R1 held through release");
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            misses++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        #1;
        check("R1 reset state");
        #6;
        rst_n = 1'b1;
        // R10: first edge after release does a load
        step(1'b0, 1'b1, 1'b0, 4'b1011, " R10 first edge");
        // Set, clear, toggle, hold in turn
        step(1'b1, 1'b1, 1'b1, '0, " R4 set");
        step(1'b1, 1'b0, 1'b0, '0, " R5 clear");
        step(1'b1, 1'b1, 1'b0, '0, " R6 toggle from 0");
        step(1'b1, 1'b1, 1'b0, '0, " R6 toggle from 1");
        step(1'b1, 1'b0, 1'b1, '0, " R7 hold 0");
        step(1'b1, 1'b1, 1'b1, '0, "");
        step(1'b1, 1'b0, 1'b1, '0, " R7 hold 1");
        // R2: J/K values that would change stage 0 must not matter on a load
        step(1'b0, 1'b1, 1'b0, 4'b0110, " R2 jk ignored");
        step(1'b0, 1'b1, 1'b1, 4'b0000, " R2 jk ignored");
        // Back-to-back load and shift
        step(1'b0, 1'b0, 1'b0, 4'b1001, "");
        step(1'b1, 1'b0, 1'b0, 4'b1111, " R3 after load");
        step(1'b0, 1'b1, 1'b1, 4'b0101, "");
        // R9: tied J/K acts as D input
        for (int b = 0; b < 8; b++) begin
            logic dv;
            dv = logic'((8'b1011_0010 >> b) & 1);
            step(1'b1, dv, dv, '0, " R9 d-entry");
        end
        // R1 / R10: reset in mid-sequence, then shift on first edge
        mid_reset(1);
        step(1'b1, 1'b1, 1'b0, '0, " R10 shift after release");
        // Random mix with occasional mid-cycle resets
        for (int n = 0; n < 400; n++) begin
            logic [3:0] r;
            r = 4'($urandom);
            if (n % 53 == 27) mid_reset(1 + int'($urandom % 2));
            else step(r[3] & r[2] ? 1'b0 : 1'b1, r[1], r[0], 4'($urandom), "");
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule